// File: doc/BRIEF.md
# Power and Sleep Controller

This block sets the clock and reset condition of a group of on-chip modules, each of which belongs to one of a few power domains. Software reaches it through a simple register bus with address, write data, write strobe, read strobe and read data. For each module, software writes a requested next state into that module's control register. Nothing changes until software writes a per-domain GO bit into the command register. The domain engine then applies every staged request of the modules in that domain together. Each module drives a clock-enable and a local-reset output, and each domain drives a power-switch output.

A domain that is already powered finishes its transition a fixed settle time after GO. A domain that is off must first have its power-on request bit set in its domain control register before GO is accepted. After GO, the domain raises its external power request bit and holds the transition until software sets the power-good bit in the same control register. It then settles and reports itself powered. No power-down sequence is defined.

Every domain runs a small state machine with three states: `D_IDLE` (no transition), `D_WAIT_PG` (external power requested, waiting for power-good) and `D_SETTLE` (a fixed count before the new states are applied). The transitions are:
- `D_IDLE`→`D_SETTLE`: GO is written while the domain is on.
- `D_IDLE`→`D_WAIT_PG`: GO is written while the domain is off and its request bit is set.
- `D_WAIT_PG`→`D_SETTLE`: the power-good bit reads 1.
- `D_SETTLE`→`D_IDLE`: the settle counter reaches zero. The staged states are applied and the domain is marked on.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset:
  - every module status reads state 0x2 with bit 12 clear;
  - clock-enables and local resets are all low;
  - domain 0 reads powered (bit 0 of 0x200 is 1) and domain 1 reads off (bit 0 of 0x204 is 0);
  - the transition status (0x128) and the external power request (0x070) read 0;
  - the power switch is closed only for domain 0.
- R2: A write to module m's control register (0xA00+4m) stores only bits [4:0], and reads back with all other bits 0. The module's status (0x800+4m) does not change until a GO for its domain completes.
- R3: A write to the command register (0x120) with bit d set starts a transition in domain d. The command register always reads 0.
- R4: In a domain that is on, bit d of 0x128 reads 1 from the clock edge that accepts GO until the 4th rising edge after it. At that edge the bit clears, and each module of the domain takes its staged state. Modules of other domains are unchanged.
- R5: The module status reads the current state in bits [4:0] and the clock-running flag in bit 12. Bit 12 is 1 exactly for state 0x1 (sync-reset) and state 0x3 (enable).
- R6: The module clock-enable output is high for states 0x1 and 0x3. The local-reset output is high for states 0x0 (software-reset-disable) and 0x1.
- R7: GO for a domain that is off, with bit 0 of its control register (0x300+4d) clear, is ignored: no transition starts, the switch stays open and no module changes.
- R8: GO for an off domain with bit 0 set does the following:
  - it raises bit d of 0x070 and bit d of 0x128;
  - it closes the domain's power switch;
  - it holds the transition for as long as bit 8 of 0x300+4d is 0.
- R9: After bit 8 is written to 1 at clock edge p, bit d of 0x070 clears at edge p+1. The transition completes at edge p+5, where bit 0 of 0x200+4d becomes 1 and the staged states are applied.
- R10: A GO that arrives while its domain is already transitioning is ignored. It neither restarts nor extends the transition.
- R11: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read data is combinational |
| bus_rdata | output | 32 | Read data, 0 when bus_re is low |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst | output | N_MOD | Per-module local reset, active high |
| dom_pwr_sw | output | N_DOM | Per-domain power switch, 1 means closed |

## Verification
The bench runs the staged-apply function with several patterns:
- A mixed set of four states in domain 0 only. This separates the staged values from the applied ones and shows that the other domain is left alone.
- A full sweep that rotates all four states across all eight modules. This covers every state in every module against the arithmetically computed status word, clock-enable and reset.
- A power-up of the off domain, where GO is first given without the request bit and then with it. This separates the ignored case from the handshake case.
- A second GO issued mid-transition. This separates ignoring a GO from restarting the transition, through the cycle at which the busy bit clears.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ST_W   = 5;

    // module state codes
    localparam logic [ST_W-1:0] MS_SWRST   = 5'h0;
    localparam logic [ST_W-1:0] MS_SYNCRST = 5'h1;
    localparam logic [ST_W-1:0] MS_DISABLE = 5'h2;
    localparam logic [ST_W-1:0] MS_ENABLE  = 5'h3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_EXT_REQ   = 12'h070;
    localparam logic [ADDR_W-1:0] A_GO_CMD    = 12'h120;
    localparam logic [ADDR_W-1:0] A_BUSY      = 12'h128;
    localparam logic [ADDR_W-1:0] A_DOM_STAT  = 12'h200;
    localparam logic [ADDR_W-1:0] A_DOM_CTL   = 12'h300;
    localparam logic [ADDR_W-1:0] A_MOD_STAT  = 12'h800;
    localparam logic [ADDR_W-1:0] A_MOD_CTL   = 12'hA00;

    localparam int CLK_RUN_BIT = 12;
    localparam int PWR_REQ_BIT = 0;
    localparam int PWR_OK_BIT  = 8;

    typedef enum logic [1:0] {
        D_IDLE    = 2'd0,
        D_WAIT_PG = 2'd1,
        D_SETTLE  = 2'd2
    } dom_state_e;

endpackage

// File: rtl/psc_domain_fsm.sv
module psc_domain_fsm
    import pwr_sleep_pkg::*;
#(
    parameter int   SETTLE_CYC  = 4,
    parameter logic ON_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic pwr_req,
    input  logic pwr_good,
    output logic busy,
    output logic ext_req,
    output logic dom_on,
    output logic pwr_sw,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYC - 1);

    dom_state_e st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic on_q, sw_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            D_IDLE: begin
                if (go && on_q)          st_d = D_SETTLE;
                else if (go && pwr_req)  st_d = D_WAIT_PG;
            end
            D_WAIT_PG: if (pwr_good)     st_d = D_SETTLE;
            D_SETTLE:  if (cnt_q == '0)  st_d = D_IDLE;
            default:                     st_d = D_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= D_IDLE;
        else        st_q <= st_d;
    end

    // counter, power and switch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            on_q  <= ON_AT_RESET;
            sw_q  <= ON_AT_RESET;
        end else begin
            if (st_d == D_SETTLE && st_q != D_SETTLE) cnt_q <= CNT_LOAD;
            else if (st_q == D_SETTLE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (st_q == D_IDLE && st_d == D_WAIT_PG)  sw_q <= 1'b1;
            if (st_q == D_SETTLE && cnt_q == '0)      on_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy    = (st_q != D_IDLE);
        ext_req = (st_q == D_WAIT_PG);
        done    = (st_q == D_SETTLE) && (cnt_q == '0);
        dom_on  = on_q;
        pwr_sw  = sw_q;
    end

    // R8
    wait_only_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == D_WAIT_PG) |-> (!on_q && sw_q));

    // R4
    settle_ends_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == D_SETTLE && cnt_q == '0) |=> (st_q == D_IDLE && on_q));

    // R9
    power_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_q) |-> ($past(st_q) == D_SETTLE));

    // R10
    busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == D_SETTLE && cnt_q != '0) |=> (st_q == D_SETTLE && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/psc_mod_slot.sv
module psc_mod_slot
    import pwr_sleep_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            apply,
    input  logic [ST_W-1:0] next_st,
    output logic [ST_W-1:0] cur_st,
    output logic            clk_en,
    output logic            lrst
);
    logic [ST_W-1:0] st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= MS_DISABLE;
        else if (apply) st_q <= next_st;
    end

    always_comb begin
        cur_st = st_q;
        clk_en = (st_q == MS_SYNCRST) || (st_q == MS_ENABLE);
        lrst   = (st_q == MS_SWRST)   || (st_q == MS_SYNCRST);
    end

    // R2
    staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(st_q));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int N_MOD      = 8,
    parameter int N_DOM      = 2,
    parameter int SETTLE_CYC = 4,
    parameter int DW         = (N_DOM > 1) ? $clog2(N_DOM) : 1,
    parameter logic [N_MOD*DW-1:0] MOD_DOM_MAP = 8'b1111_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_MOD-1:0]  mod_clk_en,
    output logic [N_MOD-1:0]  mod_rst,
    output logic [N_DOM-1:0]  dom_pwr_sw
);
    logic [ST_W-1:0] ctl_q [N_MOD];
    logic [ST_W-1:0] cur_st [N_MOD];
    logic [N_DOM-1:0] req_q, pg_q, go, busy, ext_req, dom_on, done;

    // register file writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < N_MOD; m++) ctl_q[m] <= MS_DISABLE;
            req_q <= '0;
            pg_q  <= '0;
        end else if (bus_we) begin
            for (int m = 0; m < N_MOD; m++)
                if (bus_addr == A_MOD_CTL + ADDR_W'(4*m)) ctl_q[m] <= bus_wdata[ST_W-1:0];
            for (int d = 0; d < N_DOM; d++)
                if (bus_addr == A_DOM_CTL + ADDR_W'(4*d)) begin
                    req_q[d] <= bus_wdata[PWR_REQ_BIT];
                    pg_q[d]  <= bus_wdata[PWR_OK_BIT];
                end
        end
    end

    assign go = (bus_we && bus_addr == A_GO_CMD) ? bus_wdata[N_DOM-1:0] : '0;

    generate
        for (genvar d = 0; d < N_DOM; d++) begin : g_dom
            psc_domain_fsm #(
                .SETTLE_CYC (SETTLE_CYC),
                .ON_AT_RESET(d == 0)
            ) u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .go      (go[d]),
                .pwr_req (req_q[d]),
                .pwr_good(pg_q[d]),
                .busy    (busy[d]),
                .ext_req (ext_req[d]),
                .dom_on  (dom_on[d]),
                .pwr_sw  (dom_pwr_sw[d]),
                .done    (done[d])
            );
        end
        for (genvar m = 0; m < N_MOD; m++) begin : g_mod
            localparam int DOM = int'(MOD_DOM_MAP[m*DW +: DW]);
            psc_mod_slot u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .apply  (done[DOM]),
                .next_st(ctl_q[m]),
                .cur_st (cur_st[m]),
                .clk_en (mod_clk_en[m]),
                .lrst   (mod_rst[m])
            );
        end
    endgenerate

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (bus_addr == A_EXT_REQ) bus_rdata[N_DOM-1:0] = ext_req;
            if (bus_addr == A_BUSY)    bus_rdata[N_DOM-1:0] = busy;
            for (int d = 0; d < N_DOM; d++) begin
                if (bus_addr == A_DOM_STAT + ADDR_W'(4*d)) bus_rdata[0] = dom_on[d];
                if (bus_addr == A_DOM_CTL + ADDR_W'(4*d)) begin
                    bus_rdata[PWR_REQ_BIT] = req_q[d];
                    bus_rdata[PWR_OK_BIT]  = pg_q[d];
                end
            end
            for (int m = 0; m < N_MOD; m++) begin
                if (bus_addr == A_MOD_CTL + ADDR_W'(4*m)) bus_rdata[ST_W-1:0] = ctl_q[m];
                if (bus_addr == A_MOD_STAT + ADDR_W'(4*m)) begin
                    bus_rdata[ST_W-1:0]   = cur_st[m];
                    bus_rdata[CLK_RUN_BIT] = mod_clk_en[m];
                end
            end
        end
    end

    // R8
    req_needs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |ext_req |-> ((ext_req & ~dom_pwr_sw) == '0) && ((ext_req & busy) == ext_req));

    // R9
    req_drop_after_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_req & pg_q) != '0) |=> ((ext_req & $past(ext_req & pg_q)) == '0));
endmodule

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;
    localparam int N_MOD = 8;
    localparam int N_DOM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [N_MOD-1:0] mod_clk_en, mod_rst;
    logic [N_DOM-1:0] dom_pwr_sw;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwr_sleep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .mod_clk_en(mod_clk_en), .mod_rst(mod_rst), .dom_pwr_sw(dom_pwr_sw)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_re = 1'b0;
    endtask

    function automatic logic [31:0] stat_word(input int s);
        return 32'(s) | (((s == 1) || (s == 3)) ? 32'h1000 : 32'h0);
    endfunction

    task automatic chk_mod(input string req, input int m, input int s);
        logic [31:0] v;
        rd(12'h800 + 12'(4*m), v);
        check(req, v, stat_word(s));
        check(req, 32'(mod_clk_en[m]), 32'((s == 1) || (s == 3)));
        check(req, 32'(mod_rst[m]), 32'((s == 0) || (s == 1)));
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int m = 0; m < N_MOD; m++) chk_mod("R1", m, 2);
        rd(12'h200, v); check("R1", v, 1);
        rd(12'h204, v); check("R1", v, 0);
        rd(12'h128, v); check("R1", v, 0);
        rd(12'h070, v); check("R1", v, 0);
        check("R1", 32'(dom_pwr_sw), 32'h1);
        // R11 unmapped
        rd(12'h004, v); check("R11", v, 0);
        rd(12'hFFC, v); check("R11", v, 0);

        // R2 staging, masked control
        wr(12'hA00, 32'hFFFF_FFE3);
        wr(12'hA04, 32'h1);
        wr(12'hA08, 32'h0);
        wr(12'hA0C, 32'h2);
        wr(12'hA10, 32'h3);
        rd(12'hA00, v); check("R2", v, 32'h3);
        chk_mod("R2", 0, 2);
        chk_mod("R2", 1, 2);

        // R3/R4 GO on powered domain 0
        wr(12'h120, 32'h1);
        rd(12'h128, v); check("R4", v, 1);
        rd(12'h120, v); check("R3", v, 0);
        repeat (3) @(negedge clk);
        rd(12'h128, v); check("R4", v, 1);
        chk_mod("R4", 0, 2);
        @(negedge clk);
        rd(12'h128, v); check("R4", v, 0);
        chk_mod("R5", 0, 3);
        chk_mod("R6", 1, 1);
        chk_mod("R6", 2, 0);
        chk_mod("R4", 3, 2);
        chk_mod("R4", 4, 2);

        // R7 GO on off domain without request
        wr(12'h120, 32'h2);
        rd(12'h128, v); check("R7", v, 0);
        repeat (5) @(negedge clk);
        rd(12'h070, v); check("R7", v, 0);
        check("R7", 32'(dom_pwr_sw), 32'h1);
        chk_mod("R7", 4, 2);

        // R8 request + GO on off domain
        wr(12'h304, 32'h1);
        wr(12'h120, 32'h2);
        rd(12'h070, v); check("R8", v, 2);
        rd(12'h128, v); check("R8", v, 2);
        check("R8", 32'(dom_pwr_sw), 32'h3);
        repeat (10) @(negedge clk);
        rd(12'h070, v); check("R8", v, 2);
        rd(12'h204, v); check("R8", v, 0);
        chk_mod("R8", 4, 2);

        // R9 power good
        wr(12'h304, 32'h101);
        rd(12'h070, v); check("R9", v, 2);
        @(negedge clk);
        rd(12'h070, v); check("R9", v, 0);
        rd(12'h128, v); check("R9", v, 2);
        repeat (3) @(negedge clk);
        rd(12'h128, v); check("R9", v, 2);
        rd(12'h204, v); check("R9", v, 0);
        @(negedge clk);
        rd(12'h128, v); check("R9", v, 0);
        rd(12'h204, v); check("R9", v, 1);
        chk_mod("R9", 4, 3);

        // R10 GO while busy
        for (int m = 0; m < 4; m++) wr(12'hA00 + 12'(4*m), 32'h1);
        wr(12'h120, 32'h1);
        wr(12'h120, 32'h1);
        @(negedge clk);
        rd(12'h128, v); check("R10", v, 1);
        @(negedge clk);
        rd(12'h128, v); check("R10", v, 0);
        chk_mod("R10", 0, 1);

        // sweep of all states across all modules
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < N_MOD; m++) wr(12'hA00 + 12'(4*m), 32'((s + m) % 4));
            wr(12'h120, 32'h3);
            repeat (4) @(negedge clk);
            rd(12'h128, v); check("R4", v, 0);
            for (int m = 0; m < N_MOD; m++) chk_mod("R5", m, (s + m) % 4);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule